// File: doc/BRIEF.md
# Peripheral Soft-Reset Sequencer

This block is a small bus master that brings one peripheral through its complete soft-reset handshake. The peripheral exposes a single 32-bit control word with three addresses:

- a plain read address;
- a set alias at read address + 4, where a write ORs the data into the word;
- a clear alias at read address + 8, where a write removes the data bits from the word.

Two bits of that word matter here: soft-reset at bit 31 and clock-gate at bit 30. The sequencer never does a read-modify-write. It changes a bit only by writing a one-hot mask to one of the aliases. It then polls the read address until the bit shows the value the step waits for.

A requester pulses `start`. The sequencer then runs five steps in a fixed order:

1. It clears soft-reset and waits for bit 31 to read 0.
2. It clears clock-gate and at once sets soft-reset, with no read in between.
3. It waits for bit 30 to read 1, which shows that the peripheral has gated its own clock while held in reset.
4. It clears soft-reset and waits for bit 31 to read 0.
5. It clears clock-gate and waits for bit 30 to read 0.

Polls are paced by a one-microsecond tick. Each wait may issue at most `POLL_LIMIT` reads. When that budget runs out, the whole sequence stops at once. At the end `done` pulses for one cycle, and `error` tells whether a wait ran out.

Top module: `periph_reset_seq`

## Requirements
- R1: After reset `done`, `error`, `busWe` and `busRe` are 0, and no bus access takes place until `start` is pulsed.
- R2: Every write carries a one-hot mask, either bit 31 (soft-reset) or bit 30 (clock-gate). It goes to `BASE_ADDR+4` (set alias) or `BASE_ADDR+8` (clear alias), never to `BASE_ADDR`.
- R3: A successful run makes exactly five writes, in this order: clear bit 31, clear bit 30, set bit 31, clear bit 31, clear bit 30. No read is issued between the second and the third write.
- R4: Polls are single-cycle reads of `BASE_ADDR`. A read is issued only in the cycle after `usTick` was high, and never while an earlier read still awaits `busRvalid`.
- R5: A wait ends on the first response showing its target value: bit 31 = 0 after the first write, bit 30 = 1 after the third, bit 31 = 0 after the fourth, and bit 30 = 0 after the fifth. Its number of reads equals the number of responses up to and including that one.
- R6: Each wait issues at most `POLL_LIMIT` reads, and the budget is reloaded at the start of every wait. A miss on the last allowed read ends the sequence with no further bus access.
- R7: On success `done` is high for exactly one cycle with `error` = 0.
- R8: After a timeout `done` pulses with `error` = 1. `error` keeps its value until the next accepted `start`, which clears it.
- R9: A `start` pulse while a sequence is running has no effect: no extra write, read or `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to run the sequence |
| usTick | input | 1 | One-cycle pulse per microsecond, paces the polls |
| done | output | 1 | One-cycle pulse when the sequence ends |
| error | output | 1 | 1 if a wait ran out of polls; valid with `done` |
| busAddr | output | ADDR_W | Register address |
| busWe | output | 1 | Single-cycle write strobe |
| busWdata | output | DATA_W | Write data (one-hot mask) |
| busRe | output | 1 | Single-cycle read strobe |
| busRdata | input | DATA_W | Read data, valid with `busRvalid` |
| busRvalid | input | 1 | One-cycle read response |

## Verification
The hardest case to reach from the ports is a wait whose poll budget runs out exactly at its limit, or misses by one read. It is harder still when this must happen in a late step while earlier steps succeed. The bench's peripheral model has per-run knobs for this:

- a lag on how many reads keep showing soft-reset after it was cleared;
- a lag before clock-gate appears;
- stuck bits that never reach their target value.

A lag of `POLL_LIMIT-1` in both soft-reset waits proves that the budget reloads. Stuck bits push a timeout into step 1, 3 or 5 in turn, and each run's write trace and per-wait read counts are compared with values worked out from the requirements.

// File: rtl/prs_pkg.sv
package prs_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_W1,    // clear soft-reset
    S_P1,    // wait soft-reset low
    S_W2A,   // clear clock-gate
    S_W2B,   // set soft-reset
    S_P3,    // wait clock-gate high
    S_W4,    // clear soft-reset
    S_P4,    // wait soft-reset low
    S_W5,    // clear clock-gate
    S_P5     // wait clock-gate low
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;     // issue a write this cycle
    logic toSet;    // 1: set alias, 0: clear alias
    logic selGate;  // 1: clock-gate bit, 0: soft-reset bit (write and check)
    logic chkWant;  // value the polled bit must show
    logic rdReq;    // issue a poll read
    logic cntLoad;  // reload the poll budget
    logic cntDec;   // consume one poll
  } seqCmd_t;

  // status from datapath to control
  typedef struct packed {
    logic rspValid;
    logic rspMet;
    logic lastTry;
  } seqStat_t;

endpackage

// File: rtl/prs_datapath.sv
module prs_datapath
  import prs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h1000,
  parameter int SET_OFS = 4,
  parameter int CLR_OFS = 8,
  parameter int SRST_BIT = 31,
  parameter int GATE_BIT = 30,
  parameter int POLL_LIMIT = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqCmd_t           cmd,
  output seqStat_t          status,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busWe,
  output logic [DATA_W-1:0] busWdata,
  output logic              busRe,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busRvalid
);

  localparam int CNT_W = $clog2(POLL_LIMIT + 1);
  localparam logic [ADDR_W-1:0] SET_ADDR = BASE_ADDR + ADDR_W'(SET_OFS);
  localparam logic [ADDR_W-1:0] CLR_ADDR = BASE_ADDR + ADDR_W'(CLR_OFS);
  localparam logic [DATA_W-1:0] SRST_MASK = DATA_W'(1) << SRST_BIT;
  localparam logic [DATA_W-1:0] GATE_MASK = DATA_W'(1) << GATE_BIT;
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(POLL_LIMIT);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic              weQ;
  logic              reQ;
  logic [CNT_W-1:0]  cntQ;
  logic              polledBit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrQ  <= BASE_ADDR;
      wdataQ <= '0;
      weQ    <= 1'b0;
      reQ    <= 1'b0;
    end else begin
      weQ <= cmd.wrEn;
      reQ <= cmd.rdReq;
      if (cmd.wrEn) begin
        addrQ  <= cmd.toSet ? SET_ADDR : CLR_ADDR;
        wdataQ <= cmd.selGate ? GATE_MASK : SRST_MASK;
      end else if (cmd.rdReq) begin
        addrQ <= BASE_ADDR;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntQ <= CNT_INIT;
    end else if (cmd.cntLoad) begin
      cntQ <= CNT_INIT;
    end else if (cmd.cntDec) begin
      cntQ <= cntQ - CNT_W'(1);
    end
  end

  assign polledBit       = cmd.selGate ? busRdata[GATE_BIT] : busRdata[SRST_BIT];
  assign status.rspValid = busRvalid;
  assign status.rspMet   = busRvalid && (polledBit == cmd.chkWant);
  assign status.lastTry  = (cntQ == CNT_W'(1));

  assign busAddr  = addrQ;
  assign busWe    = weQ;
  assign busWdata = wdataQ;
  assign busRe    = reQ;

  // R6: a poll is only consumed while budget remains beyond the last try
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.cntDec |-> (cntQ > CNT_W'(1)));

  // R2: writes carry exactly one mask bit and target an alias
  assert_onehot_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busWe |-> ($countones(busWdata) == 1));
  assert_alias_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busWe |-> (busAddr == SET_ADDR || busAddr == CLR_ADDR));

  // R4: never read and write in one cycle, reads are single-cycle
  assert_no_rw_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(busWe && busRe));
  assert_read_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busRe |=> !busRe);

endmodule

// File: rtl/prs_control.sv
module prs_control
  import prs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     usTick,
  input  seqStat_t status,
  output seqCmd_t  cmd,
  output logic     done,
  output logic     error
);

  seqState_t stateQ, stateD, afterPoll;
  logic      awaitQ, awaitD;
  logic      doneQ, errQ;
  logic      pollActive;
  logic      finOk, finErr;
  logic      startAcc;

  assign startAcc = (stateQ == S_IDLE) && start;

  always_comb begin
    cmd        = '0;
    stateD     = stateQ;
    awaitD     = awaitQ;
    pollActive = 1'b0;
    afterPoll  = S_IDLE;
    finOk      = 1'b0;
    finErr     = 1'b0;
    unique case (stateQ)
      S_IDLE: if (start) stateD = S_W1;
      S_W1: begin
        cmd.wrEn = 1'b1; cmd.cntLoad = 1'b1; stateD = S_P1;
      end
      S_P1: begin
        pollActive = 1'b1; afterPoll = S_W2A;
      end
      S_W2A: begin
        cmd.wrEn = 1'b1; cmd.selGate = 1'b1; stateD = S_W2B;
      end
      S_W2B: begin
        cmd.wrEn = 1'b1; cmd.toSet = 1'b1; cmd.cntLoad = 1'b1; stateD = S_P3;
      end
      S_P3: begin
        pollActive = 1'b1; cmd.selGate = 1'b1; cmd.chkWant = 1'b1; afterPoll = S_W4;
      end
      S_W4: begin
        cmd.wrEn = 1'b1; cmd.cntLoad = 1'b1; stateD = S_P4;
      end
      S_P4: begin
        pollActive = 1'b1; afterPoll = S_W5;
      end
      S_W5: begin
        cmd.wrEn = 1'b1; cmd.selGate = 1'b1; cmd.cntLoad = 1'b1; stateD = S_P5;
      end
      S_P5: begin
        pollActive = 1'b1; cmd.selGate = 1'b1; afterPoll = S_IDLE;
      end
      default: stateD = S_IDLE;
    endcase

    if (pollActive) begin
      if (!awaitQ) begin
        if (usTick) begin
          cmd.rdReq = 1'b1;
          awaitD    = 1'b1;
        end
      end else if (status.rspValid) begin
        awaitD = 1'b0;
        if (status.rspMet) begin
          stateD = afterPoll;
          finOk  = (stateQ == S_P5);
        end else if (status.lastTry) begin
          stateD = S_IDLE;
          finErr = 1'b1;
        end else begin
          cmd.cntDec = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ <= S_IDLE;
      awaitQ <= 1'b0;
      doneQ  <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      awaitQ <= awaitD;
      doneQ  <= finOk | finErr;
      if (finOk | finErr) begin
        errQ <= finErr;
      end else if (startAcc) begin
        errQ <= 1'b0;
      end
    end
  end

  assign done  = doneQ;
  assign error = errQ;

  // R7: done never lasts more than one cycle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: error holds while idle and no start arrives
  assert_error_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == S_IDLE && !start) |=> $stable(error));

  // R9: a running sequence never restarts at its first step
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ != S_IDLE) |=> (stateQ != S_W1));

endmodule

// File: rtl/periph_reset_seq.sv
module periph_reset_seq
  import prs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h1000,
  parameter int SET_OFS = 4,
  parameter int CLR_OFS = 8,
  parameter int SRST_BIT = 31,
  parameter int GATE_BIT = 30,
  parameter int POLL_LIMIT = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              usTick,
  output logic              done,
  output logic              error,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busWe,
  output logic [DATA_W-1:0] busWdata,
  output logic              busRe,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busRvalid
);

  seqCmd_t  cmd;
  seqStat_t status;

  prs_control ctrl_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .usTick (usTick),
    .status (status),
    .cmd    (cmd),
    .done   (done),
    .error  (error)
  );

  prs_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .BASE_ADDR  (BASE_ADDR),
    .SET_OFS    (SET_OFS),
    .CLR_OFS    (CLR_OFS),
    .SRST_BIT   (SRST_BIT),
    .GATE_BIT   (GATE_BIT),
    .POLL_LIMIT (POLL_LIMIT)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .status    (status),
    .busAddr   (busAddr),
    .busWe     (busWe),
    .busWdata  (busWdata),
    .busRe     (busRe),
    .busRdata  (busRdata),
    .busRvalid (busRvalid)
  );

  // R4: a poll read follows a tick by exactly one cycle
  assert_read_after_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busRe |-> $past(usTick));

  // R1: no bus access while the reset-state outputs are expected quiet after done
  assert_quiet_after_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busWe && !busRe));

endmodule

// File: tb/periph_reset_seq_tb_top.sv
module periph_reset_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 8;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam logic [31:0] SET_A = BASE + 32'd4;
  localparam logic [31:0] CLR_A = BASE + 32'd8;
  localparam logic [31:0] B31 = 32'h8000_0000;
  localparam logic [31:0] B30 = 32'h4000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic usTick = 1'b0;
  logic done, error, busWe, busRe;
  logic [31:0] busAddr, busWdata;
  logic [31:0] busRdata = '0;
  logic busRvalid = 1'b0;

  int testsRun = 0;
  int testsFailed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  periph_reset_seq #(.BASE_ADDR(BASE), .POLL_LIMIT(LIMIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .usTick(usTick),
    .done(done), .error(error), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRe(busRe), .busRdata(busRdata), .busRvalid(busRvalid)
  );

  // ---------------- peripheral model ----------------
  int   srstLag = 0, gateLag = 0;
  bit   stuckSrst = 0, noGate = 0, stuckGate = 0;
  bit   modelInit = 0;
  logic [31:0] periphReg = 32'hC000_0000;
  int   srstLagCnt = 0, gateCnt = 0;

  always @(posedge clk) begin
    busRvalid <= 1'b0;
    if (modelInit) begin
      periphReg  <= 32'hC000_0000;
      srstLagCnt <= 0;
      gateCnt    <= 0;
    end else if (busWe) begin
      if (busAddr == SET_A) begin
        periphReg <= periphReg | busWdata;
        if (busWdata[31]) gateCnt <= 0;
      end else if (busAddr == CLR_A) begin
        periphReg <= periphReg & ~busWdata;
        if (busWdata[31]) srstLagCnt <= srstLag;
      end
    end else if (busRe) begin
      logic [31:0] v;
      v = periphReg;
      if (srstLagCnt > 0 || stuckSrst) v[31] = 1'b1;
      if (srstLagCnt > 0) srstLagCnt <= srstLagCnt - 1;
      if (periphReg[31] && !noGate && !periphReg[30]) begin
        if (gateCnt >= gateLag) begin
          periphReg[30] <= 1'b1;
          v[30] = 1'b1;
        end else begin
          gateCnt <= gateCnt + 1;
        end
      end
      if (stuckGate) v[30] = 1'b1;
      busRdata  <= v;
      busRvalid <= 1'b1;
    end
  end

  // ---------------- monitor and tick generator ----------------
  bit   logClear = 0;
  int   wrN = 0, rdTotal = 0, doneCnt = 0, tickViol = 0, pendViol = 0, doneWide = 0;
  logic [31:0] wrAddr [8];
  logic [31:0] wrData [8];
  int   readsAfter [8];
  bit   errAtDone = 0;
  bit   pending = 0;
  bit   prevDone = 0;
  int   tickDiv = 0;

  always @(negedge clk) begin
    if (logClear) begin
      wrN = 0; rdTotal = 0; doneCnt = 0; tickViol = 0; pendViol = 0; doneWide = 0;
      for (int i = 0; i < 8; i++) readsAfter[i] = 0;
    end
    if (busWe && wrN < 8) begin
      wrAddr[wrN] = busAddr; wrData[wrN] = busWdata; wrN++;
    end
    if (busRe) begin
      rdTotal++;
      if (wrN > 0) readsAfter[wrN-1]++;
      if (!usTick) tickViol++;
      if (pending) pendViol++;
      if (busAddr != BASE) pendViol++;
      pending = 1;
    end else if (busRvalid) begin
      pending = 0;
    end
    if (done) begin
      doneCnt++;
      errAtDone = error;
      if (prevDone) doneWide++;
    end
    prevDone = done;
    tickDiv = (tickDiv + 1) % 4;
    usTick = (tickDiv == 0);
  end

  // ---------------- helpers ----------------
  task automatic step();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic prepare(input int sl, input int gl, input bit sS, input bit nG, input bit sG);
    srstLag = sl; gateLag = gl; stuckSrst = sS; noGate = nG; stuckGate = sG;
    modelInit = 1; logClear = 1;
    step();
    modelInit = 0; logClear = 0;
    step();
  endtask

  task automatic pulse_start();
    start = 1'b1;
    step();
    start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (doneCnt == 0 && n < 3000) begin
      step();
      n++;
    end
    repeat (30) step();
  endtask

  task automatic check_writes(input int n, input string req);
    logic [31:0] expA [5];
    logic [31:0] expD [5];
    expA = '{CLR_A, CLR_A, SET_A, CLR_A, CLR_A};
    expD = '{B31, B30, B31, B31, B30};
    check(wrN == n, req, "write count", wrN, n);
    for (int i = 0; i < n && i < wrN; i++) begin
      check(wrAddr[i] == expA[i], req, $sformatf("write %0d addr", i), wrAddr[i], expA[i]);
      check(wrData[i] == expD[i], req, $sformatf("write %0d data", i), wrData[i], expD[i]);
    end
  endtask

  task automatic check_reads(input int r0, input int r2, input int r3, input int r4, input string req);
    check(readsAfter[0] == r0, req, "reads step1", readsAfter[0], r0);
    check(readsAfter[1] == 0, "R3", "reads between write2 and write3", readsAfter[1], 0);
    check(readsAfter[2] == r2, req, "reads step3", readsAfter[2], r2);
    check(readsAfter[3] == r3, req, "reads step4", readsAfter[3], r3);
    check(readsAfter[4] == r4, req, "reads step5", readsAfter[4], r4);
  endtask

  task automatic check_bus_rules();
    check(tickViol == 0, "R4", "reads without preceding tick", tickViol, 0);
    check(pendViol == 0, "R4", "overlapping or misaddressed reads", pendViol, 0);
    check(doneWide == 0, "R7", "done wider than one cycle", doneWide, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic test_reset();
    check(done == 0 && error == 0, "R1", "done/error after reset", {done, error}, 0);
    check(busWe == 0 && busRe == 0, "R1", "strobes after reset", {busWe, busRe}, 0);
    repeat (40) step();
    check(wrN == 0 && rdTotal == 0, "R1", "bus accesses without start", wrN + rdTotal, 0);
  endtask

  task automatic test_clean();
    prepare(0, 0, 0, 0, 0);
    pulse_start();
    wait_done();
    check_writes(5, "R3");
    check_reads(1, 1, 1, 1, "R5");
    check(doneCnt == 1, "R7", "done pulses", doneCnt, 1);
    check(errAtDone == 0, "R7", "error at done", errAtDone, 0);
    check_bus_rules();
  endtask

  task automatic test_lagged();
    prepare(3, 2, 0, 0, 0);
    pulse_start();
    wait_done();
    check_writes(5, "R2");
    check_reads(4, 3, 4, 1, "R5");
    check(errAtDone == 0, "R7", "error at done, lagged", errAtDone, 0);
    check_bus_rules();
  endtask

  task automatic test_budget_edge();
    prepare(LIMIT - 1, 0, 0, 0, 0);
    pulse_start();
    wait_done();
    check_writes(5, "R6");
    check_reads(LIMIT, 1, LIMIT, 1, "R6");
    check(errAtDone == 0, "R6", "error with budget exactly used twice", errAtDone, 0);
  endtask

  task automatic test_timeout_step1();
    prepare(LIMIT, 0, 0, 0, 0);
    pulse_start();
    wait_done();
    check_writes(1, "R6");
    check(readsAfter[0] == LIMIT, "R6", "reads before abort step1", readsAfter[0], LIMIT);
    check(errAtDone == 1, "R8", "error at done step1", errAtDone, 1);
    check(error == 1, "R8", "error held after done", error, 1);
    check(doneCnt == 1, "R8", "done pulses on timeout", doneCnt, 1);
  endtask

  task automatic test_timeout_step3();
    prepare(0, 0, 0, 1, 0);
    pulse_start();
    wait_done();
    check_writes(3, "R6");
    check(readsAfter[2] == LIMIT, "R6", "reads before abort step3", readsAfter[2], LIMIT);
    check(errAtDone == 1, "R8", "error at done step3", errAtDone, 1);
  endtask

  task automatic test_timeout_step5_then_recover();
    prepare(0, 0, 0, 0, 1);
    pulse_start();
    wait_done();
    check_writes(5, "R6");
    check(readsAfter[4] == LIMIT, "R6", "reads before abort step5", readsAfter[4], LIMIT);
    check(errAtDone == 1, "R8", "error at done step5", errAtDone, 1);
    prepare(0, 0, 0, 0, 0);
    check(error == 1, "R8", "error held while idle", error, 1);
    pulse_start();
    step();
    check(error == 0, "R8", "error cleared by accepted start", error, 0);
    wait_done();
    check(errAtDone == 0, "R8", "error after recovery run", errAtDone, 0);
  endtask

  task automatic test_start_ignored();
    prepare(2, 1, 0, 0, 0);
    pulse_start();
    repeat (6) step();
    pulse_start();
    repeat (9) step();
    pulse_start();
    wait_done();
    repeat (40) step();
    check(doneCnt == 1, "R9", "done pulses with extra starts", doneCnt, 1);
    check_writes(5, "R9");
    check_reads(3, 2, 3, 1, "R9");
  endtask

  // ---------------- main ----------------
  bit finished = 0;

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    test_reset();
    test_clean();
    test_lagged();
    test_budget_edge();
    test_timeout_step1();
    test_timeout_step3();
    test_timeout_step5_then_recover();
    test_start_ignored();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule